// File: doc/BRIEF.md
# ISA Memory and I/O Cycle Timing Sequencer

This block acts as the owner of an ISA-style expansion bus. It accepts one request at a time. A request gives the cycle type (memory or I/O), the width (8 or 16 bit), the direction, the address and the write data. The block turns the request into a cycle on a bus clock that it generates itself. It pulses the address-latch strobe, drives the address, drives the one matching command strobe (memory read, memory write, I/O read or I/O write) and, for writes, drives the data lanes. At the end of the cycle it returns the captured read data and the length of the cycle in bus periods.

The block clock runs at twice the bus clock rate, so each block clock is one half of a bus period. Cycle lengths follow the width and the type. A standard 16-bit cycle takes 3 bus periods, which includes one wait state. An 8-bit cycle takes 6 periods. A target can pull the active-low zero-wait input to end a 16-bit memory cycle after 2 periods. That input has no effect on I/O cycles or 8-bit cycles. Each cycle starts on a rising bus clock boundary, and the next request can be taken in the last half of the current cycle. Back-to-back cycles therefore follow one another with no idle time, and the spacing between them is always a whole number of periods.

Top module: `isa_cycle_seq`

## Requirements
- R1: `bclk` toggles on every `clk` edge after reset and is high in the first half of each bus period. A cycle always begins in a half where `bclk` is high, so the distance between two cycle starts is an even number of `clk` cycles.
- R2: `bale` is high for exactly the first half of each cycle. `addrBus` carries the request address from that half until the cycle ends.
- R3: The command strobe is low from the second half of the cycle through its last half, which is 2×N−1 halves for an N-period cycle. Exactly one strobe is used: `memRdN` for a memory read, `memWrN` for a memory write, `ioRdN` for an I/O read, `ioWrN` for an I/O write. No strobe is ever low while `bale` is high.
- R4: A 16-bit memory cycle lasts 3 periods when `nowsN` is high at the sampling edge.
- R5: `nowsN` is sampled at the `clk` edge that ends the third half of the cycle. If it is low on a 16-bit memory cycle, the command is released one half later and the cycle lasts 2 periods.
- R6: Every 8-bit cycle, memory or I/O, lasts 6 periods whatever the value of `nowsN`.
- R7: Every 16-bit I/O cycle lasts 3 periods whatever the value of `nowsN`.
- R8: `done` is a one-`clk` pulse in the half that follows command release. At the same edge `lastLen` takes the cycle length in periods. On reads, `rdData` takes `dataIn` as sampled at the end of the last half. For an 8-bit read only bits 7:0 are taken and bits 15:8 read as zero. Writes leave `rdData` unchanged.
- R9: `reqReady` is high only while `bclk` is low, and only when the block is idle or in the last half of a cycle. A request taken in the last half starts its `bale` half in the same half where `done` is high for the previous cycle.
- R10: During a write cycle `dataOe` is high for the whole cycle. `dataOut` carries the write data; for an 8-bit write bits 15:8 are zero.
- R11: During reset `bale` and `done` are low, all four strobes are high, `dataOe` is low and `lastLen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two per bus period |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqIsIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| reqWide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Cycle address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Request taken when high together with reqValid |
| bclk | output | 1 | Bus clock |
| bale | output | 1 | Address-latch strobe |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| addrBus | output | 24 | Address bus |
| dataOut | output | 16 | Write data lanes |
| dataOe | output | 1 | Write data lanes enable |
| dataIn | input | 16 | Read data lanes |
| nowsN | input | 1 | Zero-wait request from the target, active low |
| done | output | 1 | Cycle completed |
| rdData | output | 16 | Captured read data |
| lastLen | output | 4 | Length of the last cycle in bus periods |

## Verification
If the half counter or the end marker holds a wrong value, the fault reaches the ports within one cycle. The command-strobe span no longer equals 2×N−1 halves, `lastLen` reports a length other than 2, 3 or 6, or the next `bale` starts at the wrong half. A fault in the phase bit shows up straight away: `bale` or `reqReady` appears in the wrong half of `bclk`. A wrong latched type shows up in the first command half of the cycle, either as the wrong strobe or as a short cycle on an I/O or 8-bit access.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  parameter int SEQ_HALF_W = 4;
  parameter int SEQ_LEN_W  = 4;

  typedef struct packed {
    logic                 load;
    logic                 finish;
    logic [SEQ_LEN_W-1:0] cycLen;
  } seq_strobe_t;
endpackage

// File: rtl/isa_seq_ctrl.sv
module isa_seq_ctrl
  import isa_seq_pkg::*;
#(
  parameter int WIDE_HALVES   = 6,
  parameter int NARROW_HALVES = 12,
  parameter int SHORT_HALVES  = 4,
  parameter int NOWS_HALF     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWide,
  input  logic        nowsN,
  input  logic        curIo,
  input  logic        curWide,
  input  logic        curWrite,
  output logic        reqReady,
  output logic        bclk,
  output logic        bale,
  output logic        memRdN,
  output logic        memWrN,
  output logic        ioRdN,
  output logic        ioWrN,
  output logic        dataOe,
  output seq_strobe_t st
);
  localparam int HW = SEQ_HALF_W;
  localparam logic [HW-1:0] WIDE_END   = HW'(WIDE_HALVES - 1);
  localparam logic [HW-1:0] NARROW_END = HW'(NARROW_HALVES - 1);
  localparam logic [HW-1:0] SHORT_END  = HW'(SHORT_HALVES - 1);
  localparam logic [HW-1:0] SAMPLE_AT  = HW'(NOWS_HALF);

  logic          phase;
  logic          busy;
  logic [HW-1:0] halfIdx;
  logic [HW-1:0] endIdx;
  logic          lastHalf;
  logic          accept;
  logic          cmdOn;
  logic          shortOk;
  logic [HW:0]   endPlusOne;

  assign lastHalf = busy && (halfIdx == endIdx);
  assign reqReady = phase && (!busy || lastHalf);
  assign accept   = reqValid && reqReady;
  assign shortOk  = curWide && !curIo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      busy    <= 1'b0;
      halfIdx <= '0;
      endIdx  <= '0;
    end else begin
      phase <= ~phase;
      if (accept) begin
        busy    <= 1'b1;
        halfIdx <= '0;
        endIdx  <= reqWide ? WIDE_END : NARROW_END;
      end else if (lastHalf) begin
        busy <= 1'b0;
      end else if (busy) begin
        halfIdx <= halfIdx + 1'b1;
        if (halfIdx == SAMPLE_AT && shortOk && !nowsN) begin
          endIdx <= SHORT_END;
        end
      end
    end
  end

  assign bclk   = ~phase;
  assign bale   = busy && (halfIdx == '0);
  assign cmdOn  = busy && (halfIdx != '0);
  assign memRdN = ~(cmdOn && !curIo && !curWrite);
  assign memWrN = ~(cmdOn && !curIo && curWrite);
  assign ioRdN  = ~(cmdOn && curIo && !curWrite);
  assign ioWrN  = ~(cmdOn && curIo && curWrite);
  assign dataOe = busy && curWrite;

  assign endPlusOne = {1'b0, endIdx} + 1'b1;

  always_comb begin
    st        = '0;
    st.load   = accept;
    st.finish = lastHalf;
    st.cycLen = SEQ_LEN_W'(endPlusOne >> 1);
  end
endmodule

// File: rtl/isa_seq_dp.sv
module isa_seq_dp
  import isa_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seq_strobe_t          st,
  input  logic                 reqIsIo,
  input  logic                 reqWide,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    dataIn,
  output logic                 curIo,
  output logic                 curWide,
  output logic                 curWrite,
  output logic [ADDR_W-1:0]    addrBus,
  output logic [DATA_W-1:0]    dataOut,
  output logic [DATA_W-1:0]    rdData,
  output logic                 done,
  output logic [SEQ_LEN_W-1:0] lastLen
);
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] narrowW;
  logic [DATA_W-1:0] narrowR;

  assign narrowW = {{(DATA_W-LANE_W){1'b0}}, reqWdata[LANE_W-1:0]};
  assign narrowR = {{(DATA_W-LANE_W){1'b0}}, dataIn[LANE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIo    <= 1'b0;
      curWide  <= 1'b0;
      curWrite <= 1'b0;
      addrBus  <= '0;
      dataOut  <= '0;
      rdData   <= '0;
      done     <= 1'b0;
      lastLen  <= '0;
    end else begin
      done <= st.finish;
      if (st.finish) begin
        lastLen <= st.cycLen;
        if (!curWrite) begin
          rdData <= curWide ? dataIn : narrowR;
        end
      end
      if (st.load) begin
        curIo    <= reqIsIo;
        curWide  <= reqWide;
        curWrite <= reqWrite;
        addrBus  <= reqAddr;
        dataOut  <= reqWide ? reqWdata : narrowW;
      end
    end
  end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsIo,
  input  logic                 reqWide,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 reqReady,
  output logic                 bclk,
  output logic                 bale,
  output logic                 memRdN,
  output logic                 memWrN,
  output logic                 ioRdN,
  output logic                 ioWrN,
  output logic [ADDR_W-1:0]    addrBus,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 dataOe,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 nowsN,
  output logic                 done,
  output logic [DATA_W-1:0]    rdData,
  output logic [SEQ_LEN_W-1:0] lastLen
);
  seq_strobe_t st;
  logic curIo, curWide, curWrite;

  isa_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWide(reqWide),
    .nowsN(nowsN), .curIo(curIo), .curWide(curWide), .curWrite(curWrite),
    .reqReady(reqReady), .bclk(bclk), .bale(bale), .memRdN(memRdN),
    .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN), .dataOe(dataOe), .st(st)
  );

  isa_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqIsIo(reqIsIo), .reqWide(reqWide),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dataIn(dataIn), .curIo(curIo), .curWide(curWide), .curWrite(curWrite),
    .addrBus(addrBus), .dataOut(dataOut), .rdData(rdData), .done(done),
    .lastLen(lastLen)
  );
endmodule

// File: rtl/isa_cycle_seq_chk.sv
module isa_cycle_seq_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             bclk,
  input logic             bale,
  input logic             memRdN,
  input logic             memWrN,
  input logic             ioRdN,
  input logic             ioWrN,
  input logic             reqReady,
  input logic             done,
  input logic [LEN_W-1:0] lastLen
);
  logic anyCmd;
  assign anyCmd = !(memRdN && memWrN && ioRdN && ioWrN);

  a_r1_bale_on_high_bclk: assert property (@(posedge clk) disable iff (!rstN)
    bale |-> bclk);
  a_r1_bclk_toggles: assert property (@(posedge clk) disable iff (!rstN)
    rstN && $past(rstN) |-> bclk != $past(bclk));
  a_r2_bale_one_half: assert property (@(posedge clk) disable iff (!rstN)
    bale |=> !bale);
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~memRdN, ~memWrN, ~ioRdN, ~ioWrN}));
  a_r3_no_cmd_with_bale: assert property (@(posedge clk) disable iff (!rstN)
    bale |-> !anyCmd);
  a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(anyCmd) && !anyCmd);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_len_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lastLen == 2 || lastLen == 3 || lastLen == 6));
  a_r9_ready_low_bclk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !bclk);
endmodule

bind isa_cycle_seq isa_cycle_seq_chk #(.LEN_W(isa_seq_pkg::SEQ_LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .bclk(bclk), .bale(bale), .memRdN(memRdN),
  .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN), .reqReady(reqReady),
  .done(done), .lastLen(lastLen)
);

// File: tb/isa_cycle_seq_bench.sv
module isa_cycle_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, reqValid, reqIsIo, reqWide, reqWrite, reqReady;
  logic [23:0] reqAddr, addrBus;
  logic [15:0] reqWdata, dataOut, dataIn, rdData;
  logic        bclk, bale, memRdN, memWrN, ioRdN, ioWrN, dataOe, nowsN, done;
  logic [3:0]  lastLen;

  isa_cycle_seq u_isa_cycle_seq (.*);

  // Target model: read data derived from the address; bit 23 selects a zero-wait region.
  assign dataIn = addrBus[15:0] ^ 16'h5AC3;
  assign nowsN  = ~addrBus[23];

  typedef struct {
    logic [23:0] addr;
    logic [15:0] rd;
    logic [15:0] wd;
    int          len;
    int          kind;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0, fails = 0, tick = 0;
  int          baleTicks[$], doneTicks[$];
  logic [15:0] lastRd = 16'h0;
  int          cmdHalves = 0, baleHalves = 0, kindSeen = 0;
  logic        prevBclk = 1'b0;
  bit          live = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit io, input bit wide, input bit wr,
                       input logic [23:0] a, input logic [15:0] wd,
                       input int len, input string tag);
    item_t e;
    e.addr = a;
    e.wd   = wr ? (wide ? wd : {8'h00, wd[7:0]}) : 16'h0;
    e.len  = len;
    e.kind = io ? (wr ? 4 : 3) : (wr ? 2 : 1);
    e.tag  = tag;
    if (!wr) lastRd = wide ? (a[15:0] ^ 16'h5AC3) : {8'h00, a[7:0] ^ 8'hC3};
    e.rd = lastRd;
    sb.push_back(e);
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = io; reqWide = wide; reqWrite = wr;
    reqAddr = a; reqWdata = wd;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops expected items as cycles complete.
  always @(negedge clk) begin
    if (live) begin
      int k;
      tick++;
      check(bclk != prevBclk, "R1", "bclk toggle", bclk, !prevBclk);
      prevBclk = bclk;
      if (done) begin
        if (sb.size() == 0) begin
          check(0, "R8", "done with empty scoreboard", 1, 0);
        end else begin
          item_t e;
          e = sb.pop_front();
          check(lastLen == e.len, e.tag, "cycle length", lastLen, e.len);
          check(rdData == e.rd, "R8", "read data", rdData, e.rd);
          check(cmdHalves == 2 * e.len - 1, "R3", "command halves", cmdHalves, 2 * e.len - 1);
          check(kindSeen == e.kind, "R3", "command strobe kind", kindSeen, e.kind);
          check(baleHalves == 1, "R2", "bale halves", baleHalves, 1);
        end
        doneTicks.push_back(tick);
        cmdHalves = 0; baleHalves = 0; kindSeen = 0;
      end
      if (bale) begin
        check(bclk == 1'b1, "R1", "bale in high half", bclk, 1);
        if (sb.size() > 0) check(addrBus == sb[0].addr, "R2", "address", addrBus, sb[0].addr);
        baleHalves++;
        baleTicks.push_back(tick);
      end
      k = !memRdN ? 1 : !memWrN ? 2 : !ioRdN ? 3 : !ioWrN ? 4 : 0;
      if (k != 0) begin
        cmdHalves++;
        kindSeen = (kindSeen == 0 || kindSeen == k) ? k : 9;
        if (sb.size() > 0) check(addrBus == sb[0].addr, "R2", "address held", addrBus, sb[0].addr);
        if ((k == 2 || k == 4) && sb.size() > 0) begin
          check(dataOe == 1'b1, "R10", "data enable", dataOe, 1);
          check(dataOut == sb[0].wd, "R10", "write data", dataOut, sb[0].wd);
        end
      end
    end
  end

  task automatic run_all();
    rstN = 1'b0; reqValid = 1'b0; reqIsIo = 1'b0; reqWide = 1'b0;
    reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(bale == 1'b0 && done == 1'b0, "R11", "bale/done in reset", {bale, done}, 0);
    check({memRdN, memWrN, ioRdN, ioWrN} == 4'hF, "R11", "strobes in reset",
          {memRdN, memWrN, ioRdN, ioWrN}, 4'hF);
    check(dataOe == 1'b0 && lastLen == 0, "R11", "oe/len in reset", {dataOe, lastLen}, 0);
    rstN = 1'b1;
    prevBclk = ~bclk;
    @(posedge clk);
    @(negedge clk);
    prevBclk = ~bclk;
    live = 1'b1;

    issue(0, 1, 0, 24'h012344, 16'h0,    3, "R4");
    issue(0, 1, 0, 24'h80A5F0, 16'h0,    2, "R5");
    issue(0, 1, 1, 24'h80B000, 16'hBEEF, 2, "R5");
    issue(0, 0, 0, 24'h8000F7, 16'h0,    6, "R6");
    issue(0, 0, 1, 24'h000123, 16'h12AB, 6, "R6");
    issue(1, 1, 0, 24'h800300, 16'h0,    3, "R7");
    issue(1, 1, 1, 24'h000310, 16'h55AA, 3, "R7");
    issue(1, 0, 0, 24'h800061, 16'h0,    6, "R6");
    issue(0, 1, 1, 24'h004400, 16'hC0DE, 3, "R4");
    drain();

    // Back-to-back: zero-wait, standard 16-bit, then 8-bit.
    baleTicks.delete(); doneTicks.delete();
    issue(0, 1, 0, 24'h801234, 16'h0, 2, "R5");
    issue(0, 1, 0, 24'h005678, 16'h0, 3, "R4");
    issue(0, 0, 0, 24'h00009A, 16'h0, 6, "R6");
    drain();
    if (baleTicks.size() == 3 && doneTicks.size() == 3) begin
      check(baleTicks[1] - baleTicks[0] == 4, "R9", "spacing after zero-wait",
            baleTicks[1] - baleTicks[0], 4);
      check(baleTicks[2] - baleTicks[1] == 6, "R9", "spacing after standard",
            baleTicks[2] - baleTicks[1], 6);
      check(baleTicks[1] == doneTicks[0], "R9", "next bale with done", baleTicks[1], doneTicks[0]);
      check(baleTicks[2] == doneTicks[1], "R9", "next bale with done", baleTicks[2], doneTicks[1]);
      check((baleTicks[2] - baleTicks[0]) % 2 == 0, "R1", "whole-period spacing",
            (baleTicks[2] - baleTicks[0]) % 2, 0);
    end else begin
      check(0, "R9", "back-to-back cycle count", baleTicks.size(), 3);
    end

    // Idle request: ready only with bclk low.
    @(negedge clk);
    check(reqReady == !bclk, "R9", "idle ready phase", reqReady, !bclk);
    @(negedge clk);
    check(reqReady == !bclk, "R9", "idle ready phase", reqReady, !bclk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        check(0, "WATCHDOG", "run timed out", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule